// File: doc/BRIEF.md
# Eight-Channel Converter Serial Word Loader

This block is the digital front end of an eight-channel, 12-bit voltage-output converter. A host shifts 16-bit words in on `sdi`, most significant bit first. The block samples a bit on each falling edge of `sclk` that follows a falling edge of the active-low frame strobe `fs_n`. Each complete word names a channel and carries a 12-bit code. The code is written into that channel's holding register. The 96-bit `codes` bus carries the eight latched codes that drive the analog section.

A level-sensitive load input `load_n` joins the holding registers to the outputs. While it is low, each channel follows its holding register, so every write shows up at once. While it is high, the outputs stay frozen, and releasing it to low moves all eight channels together. The input `proc_mode` selects the framing rule. With it high, the strobe must cover all sixteen bits, an early rise discards the word, and the write happens when the strobe rises. With it low, a short strobe pulse is enough and the word is written on its sixteenth bit. The output `sdo` repeats the sampled input stream sixteen serial clocks late, so several devices can be chained.

The serial pins are sampled in the `clk` domain, so `sclk` and `fs_n` must run well below the `clk` rate.

Top module: `octdac_loader`

## Requirements
- R1: After a falling edge of `fs_n`, each falling edge of `sclk` shifts in one bit of `sdi`, first bit = word bit 15. A new `fs_n` falling edge always restarts reception at bit 15, even in the middle of a word.
- R2: Word layout: bit 15 = 0 marks a data word, bits 14..12 give the channel (0..7) and bits 11..0 give the code. A completed data word writes only the addressed channel's holding register.
- R3: While `load_n` is low, `codes[12*c+11 : 12*c]` equals channel c's holding register. A write is visible on the `clk` cycle after the edge that completes it.
- R4: While `load_n` is high, `codes` does not change. When it goes low, every channel that was written meanwhile updates at the same time.
- R5: `sdo` changes only after a falling `sclk` edge. After the n-th falling edge since reset (n ≥ 16), it holds the bit sampled at edge n−15, so a downstream device sampling on the same edges receives each bit 16 edges late.
- R6: With `proc_mode` = 1, if `fs_n` rises before the 16th falling `sclk` edge, the word is dropped and no register changes.
- R7: With `proc_mode` = 1, a full word is written only when `fs_n` rises, never at the 16th edge.
- R8: With `proc_mode` = 0, `fs_n` may return high after the first bit. The word is written at its 16th falling `sclk` edge.
- R9: A word with bit 15 = 1 is a control word and changes no register and no output.
- R10: Reset clears all holding registers, all output codes and `sdo` to zero.
- R11: If a write completes on the same `clk` edge at which `load_n` is still sampled low, the new code is kept on the outputs after `load_n` then rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock, bits taken on its falling edge |
| fs_n | input | 1 | Active-low frame strobe |
| sdi | input | 1 | Serial data in, MSB first |
| proc_mode | input | 1 | 1 = strobe must span the word, 0 = short strobe pulse |
| load_n | input | 1 | Active-low level-sensitive output load |
| sdo | output | 1 | Serial data delayed by 16 serial clocks for chaining |
| codes | output | 96 | Eight 12-bit output codes, channel 0 in bits 11..0 |

## Verification
Two things can happen on the same edge: a word write into a holding register, and the output stage sampling `load_n`. The bench ends a data word with `load_n` low and raises it on the next cycle. The outputs must keep the new code. A second run raises `load_n` before the last bit, and there the outputs must keep the old code until the load goes low again. A checker property also ties the write timing to the strobe's rising edge in processor mode.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    localparam int unsigned DEF_NCH    = 8;
    localparam int unsigned DEF_CODE_W = 12;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_FULL
    } rx_state_e;

endpackage

// File: rtl/octdac_rx.sv
module octdac_rx
    import octdac_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              fs_n,
    input  logic              sdi,
    input  logic              proc_mode,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o,
    output logic              sdo
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic              sclk;
        logic              fs_n;
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] dly;
    } rx_t;

    rx_t r_d, r_q;

    logic              sclk_fall, fs_fall, fs_rise;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        r_d       = r_q;
        r_d.sclk  = sclk;
        r_d.fs_n  = fs_n;
        sclk_fall = r_q.sclk & ~sclk;
        fs_fall   = r_q.fs_n & ~fs_n;
        fs_rise   = ~r_q.fs_n & fs_n;
        shifted   = {r_q.sr[WORD_W-2:0], sdi};
        commit_o  = 1'b0;
        word_o    = r_q.sr;

        // chain delay line runs on every serial falling edge
        if (sclk_fall) begin
            r_d.dly = {r_q.dly[WORD_W-2:0], sdi};
        end

        if (fs_fall) begin
            r_d.st  = RX_SHIFT;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                RX_SHIFT: begin
                    if (proc_mode && fs_rise) begin
                        r_d.st = RX_IDLE;            // early strobe release: drop word
                    end else if (sclk_fall) begin
                        r_d.sr  = shifted;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == LAST) begin
                            if (proc_mode) begin
                                r_d.st = RX_FULL;    // wait for strobe rise
                            end else begin
                                r_d.st   = RX_IDLE;
                                commit_o = 1'b1;
                                word_o   = shifted;
                            end
                        end
                    end
                end
                RX_FULL: begin
                    if (fs_rise) begin
                        r_d.st   = RX_IDLE;
                        commit_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sclk: 1'b0, fs_n: 1'b1, st: RX_IDLE,
                     cnt: '0, sr: '0, dly: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo = r_q.dly[WORD_W-1];

endmodule

// File: rtl/octdac_bank.sv
module octdac_bank #(
    parameter int unsigned NCH    = 8,
    parameter int unsigned CODE_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NCH)-1:0]  addr,
    input  logic [CODE_W-1:0]       code,
    input  logic                    load_n,
    output logic [NCH*CODE_W-1:0]   codes
);

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] hold;
        logic [NCH-1:0][CODE_W-1:0] lat;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (we) begin
            b_d.hold[addr] = code;
        end
        // transparent load: output stage takes the next holding value
        if (!load_n) begin
            b_d.lat = b_d.hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_out
        assign codes[ch*CODE_W +: CODE_W] = load_n ? b_q.lat[ch] : b_q.hold[ch];
    end

endmodule

// File: rtl/octdac_loader.sv
module octdac_loader #(
    parameter int unsigned NCH    = octdac_pkg::DEF_NCH,
    parameter int unsigned CODE_W = octdac_pkg::DEF_CODE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  fs_n,
    input  logic                  sdi,
    input  logic                  proc_mode,
    input  logic                  load_n,
    output logic                  sdo,
    output logic [NCH*CODE_W-1:0] codes
);

    localparam int unsigned ADDR_W = $clog2(NCH);
    localparam int unsigned WORD_W = 1 + ADDR_W + CODE_W;

    logic              commit;
    logic [WORD_W-1:0] cmd_word;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [CODE_W-1:0] wr_code;

    octdac_rx #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .fs_n      (fs_n),
        .sdi       (sdi),
        .proc_mode (proc_mode),
        .commit_o  (commit),
        .word_o    (cmd_word),
        .sdo       (sdo)
    );

    // top bit set marks a control word, which this block drops
    assign wr_en   = commit & ~cmd_word[WORD_W-1];
    assign wr_addr = cmd_word[CODE_W +: ADDR_W];
    assign wr_code = cmd_word[CODE_W-1:0];

    octdac_bank #(
        .NCH    (NCH),
        .CODE_W (CODE_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .addr   (wr_addr),
        .code   (wr_code),
        .load_n (load_n),
        .codes  (codes)
    );

endmodule

// File: rtl/octdac_loader_chk.sv
module octdac_loader_chk #(
    parameter int unsigned NCH    = 8,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned WORD_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sclk,
    input logic                  fs_n,
    input logic                  proc_mode,
    input logic                  load_n,
    input logic                  sdo,
    input logic [NCH*CODE_W-1:0] codes,
    input logic                  commit,
    input logic [WORD_W-1:0]     cmd_word
);

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (codes == '0) && !sdo);

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_n && $past(load_n) |-> $stable(codes));

    p_sdo_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sclk) |=> $stable(sdo));

    p_commit_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        proc_mode && commit |-> $rose(fs_n));

    p_ctrl_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit && cmd_word[WORD_W-1] && !load_n |=> (load_n || $stable(codes)));

endmodule

bind octdac_loader octdac_loader_chk #(
    .NCH    (NCH),
    .CODE_W (CODE_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .fs_n      (fs_n),
    .proc_mode (proc_mode),
    .load_n    (load_n),
    .sdo       (sdo),
    .codes     (codes),
    .commit    (commit),
    .cmd_word  (cmd_word)
);

// File: tb/octdac_loader_bench.sv
module octdac_loader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int CW         = 12;

    logic            clk = 1'b0;
    logic            rst_n, sclk, fs_n, sdi, proc_mode, load_n;
    logic            sdo;
    logic [NCH*CW-1:0] codes;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [CW-1:0] exp_hold [NCH];
    logic [CW-1:0] exp_lat  [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    octdac_loader u_octdac_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .fs_n      (fs_n),
        .sdi       (sdi),
        .proc_mode (proc_mode),
        .load_n    (load_n),
        .sdo       (sdo),
        .codes     (codes)
    );

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int ch = 0; ch < NCH; ch++) begin
            chk(req, 32'(codes[ch*CW +: CW]), 32'(load_n ? exp_lat[ch] : exp_hold[ch]));
        end
    endtask

    task automatic note_write(input logic [15:0] w);
        if (!w[15]) begin
            exp_hold[w[14:12]] = w[11:0];
            if (!load_n) exp_lat[w[14:12]] = w[11:0];
        end
    endtask

    task automatic set_load(input logic v);
        load_n = v;
        if (!v) for (int ch = 0; ch < NCH; ch++) exp_lat[ch] = exp_hold[ch];
        tick;
    endtask

    task automatic shift_bit(input logic b);
        sdi = b; sclk = 1'b1; tick;
        sclk = 1'b0; tick;
    endtask

    task automatic send_word(input logic [15:0] w, input bit early);
        fs_n = 1'b0; tick;
        for (int i = 0; i < 16; i++) begin
            shift_bit(w[15-i]);
            if (early && i == 0) fs_n = 1'b1;
        end
        fs_n = 1'b1; tick;
        note_write(w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            report;
        end
    end

    initial begin
        logic [15:0] w;
        logic [31:0] pat;
        rst_n = 1'b0; sclk = 1'b0; fs_n = 1'b1; sdi = 1'b0;
        proc_mode = 1'b0; load_n = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin exp_hold[ch] = '0; exp_lat[ch] = '0; end
        repeat (3) tick;
        rst_n = 1'b1; tick;

        // R10: reset state
        check_all("R10 reset codes");
        chk("R10 reset sdo", 32'(sdo), 32'd0);

        // R1 R2 R3 R8 R7: sweep channels and codes in both framing modes
        for (int m = 0; m < 2; m++) begin
            proc_mode = m[0];
            for (int ch = 0; ch < NCH; ch++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [11:0] c;
                    c = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF
                        : 12'(ch * 12'h251 + 12'h0A5 + m * 12'h03C);
                    w = {1'b0, 3'(ch), c};
                    send_word(w, (m == 0) && (k == 2));
                    check_all(m ? "R7 R2 R1 proc sweep" : "R8 R2 R3 dsp sweep");
                end
            end
        end

        // R7: processor mode, no write before strobe rises
        proc_mode = 1'b1;
        w = 16'h3A5C;
        fs_n = 1'b0; tick;
        for (int i = 0; i < 16; i++) shift_bit(w[15-i]);
        check_all("R7 pending before rise");
        fs_n = 1'b1; tick; note_write(w);
        check_all("R7 after rise");

        // R6: early rise aborts, trailing clocks ignored
        w = 16'h5123;
        fs_n = 1'b0; tick;
        for (int i = 0; i < 10; i++) shift_bit(w[15-i]);
        fs_n = 1'b1; tick;
        for (int i = 10; i < 16; i++) shift_bit(w[15-i]);
        check_all("R6 aborted word");
        send_word(16'h5777, 1'b0);
        check_all("R6 next word after abort");

        // R9: control words ignored in both modes
        send_word(16'hBABC, 1'b0);
        check_all("R9 control proc");
        proc_mode = 1'b0;
        send_word(16'hF00F, 1'b1);
        check_all("R9 control dsp");

        // R1: restart on a fresh strobe fall in the middle of a word
        fs_n = 1'b0; tick;
        for (int i = 0; i < 7; i++) shift_bit(i[0]);
        fs_n = 1'b1; tick;
        send_word(16'h6D4B, 1'b0);
        check_all("R1 restart mid word");

        // R4: frozen outputs while load high, joint update on release
        set_load(1'b1);
        for (int ch = 0; ch < NCH; ch++) send_word({1'b0, 3'(ch), 12'(12'h700 + ch * 12'h011)}, 1'b1);
        check_all("R4 frozen while high");
        set_load(1'b0);
        check_all("R4 simultaneous update");

        // R11: write on the edge that still samples load low, then release
        w = 16'h2ACE;
        fs_n = 1'b0; tick;
        for (int i = 0; i < 15; i++) shift_bit(w[15-i]);
        sdi = w[0]; sclk = 1'b1; tick;
        sclk = 1'b0; tick;
        note_write(w);
        load_n = 1'b1; tick;
        fs_n = 1'b1; tick;
        check_all("R11 write kept after release");
        // contrast: load released before the final bit keeps old code
        w = 16'h2111;
        fs_n = 1'b0; tick;
        for (int i = 0; i < 15; i++) shift_bit(w[15-i]);
        load_n = 1'b1;
        shift_bit(w[0]);
        fs_n = 1'b1; tick; note_write(w);
        check_all("R11 release before write");
        set_load(1'b0);
        check_all("R11 later load");

        // R5: chain output delayed by 16 falling edges
        pat = 32'hC3A5_9E17;
        fs_n = 1'b0; tick;
        for (int n = 1; n <= 32; n++) begin
            shift_bit(pat[32-n]);
            if (n >= 16) chk("R5 sdo delay", 32'(sdo), 32'(pat[47-n]));
        end
        fs_n = 1'b1; tick;
        check_all("R9 R5 chain stream control word");

        done = 1'b1;
        report;
    end

endmodule